// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block applies one integer operation to every lane of two 64-bit packed operands in the same cycle. The lane width is picked per operation at 8, 16, 32 or 64 bits, so one beat carries eight bytes, four halfwords, two words or one doubleword. Each lane is computed on its own, and no carry, borrow or clamp crosses a lane boundary.

The operations are add and subtract, each with three overflow policies: wrap modulo the lane width, clamp to signed bounds, or clamp to unsigned bounds. There are also two compares, lane equality and signed greater-than. A compare writes a mask of all ones or all zeros that fills each lane. The logical operations AND, AND-NOT, OR and XOR let software use such a mask for per-lane conditional assignment. For example, ANDing a mask with data zeroes the lanes whose compare failed.

Operands enter on a valid/ready stream and the result leaves on a second valid/ready stream through a single output register. An input beat is accepted in a cycle where `in_valid` and `in_ready` are both high. The result of that beat is presented one cycle later. While the output is held by a low `out_ready`, the block drops `in_ready` and keeps the presented result unchanged until it is taken. In a cycle where the output is taken, a new input can be accepted.

Top module: `simd_packed_alu`

## Requirements
- R1: `lane_sz` selects the lane width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). Every lane is computed independently, and no carry, borrow or clamp passes between lanes.
- R2: Opcode 0 gives a + b and opcode 3 gives a − b in each lane, both modulo 2^W for lane width W.
- R3: Opcodes 1 (add) and 4 (subtract) treat lanes as two's complement. A result above 2^(W−1)−1 becomes that value, and one below −2^(W−1) becomes −2^(W−1). For byte lanes, 7Fh+01h gives 7Fh and 80h−01h gives 80h.
- R4: Opcodes 2 (add) and 5 (subtract) treat lanes as unsigned. A result above 2^W−1 becomes all ones, and one below zero becomes zero.
- R5: Opcode 6 (equal) and opcode 7 (signed a greater than b) write all ones to a lane where the test holds and all zeros where it fails.
- R6: Opcodes 8, 9, 10 and 11 give a AND b, (NOT a) AND b, a OR b and a XOR b.
- R7: Opcodes 12 to 15 give an all-zero result.
- R8: A beat is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. After that edge, `out_valid` is high and `out_data` holds that beat's result.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_data` stay unchanged at the next edge.
- R10: While `rst_n` is low, `out_valid` is 0 and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can accept a beat this cycle |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| op | input | 4 | Operation code (R2 to R7) |
| lane_sz | input | 2 | Lane width code (R1) |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Packed result |

## Verification
The two functions that can fall in the same cycle are draining the held result and accepting a new beat. When `out_ready` is high while a result is presented, the same edge both retires the old result and loads the new one. The bench provokes this by streaming with `in_valid` and `out_ready` toggled at random, so back-to-back accepts, stalls and simultaneous drain-and-load all occur. It judges the outcome by keeping an ordered queue of expected results from its own lane model. It pops the queue on every output transfer and checks that each stalled result survives unchanged into the next cycle.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int SIMD_DATA_W = 64;
  localparam int SIMD_N_SIZES = 4;

  typedef enum logic [3:0] {
    OP_ADD_WRAP = 4'd0,
    OP_ADD_SSAT = 4'd1,
    OP_ADD_USAT = 4'd2,
    OP_SUB_WRAP = 4'd3,
    OP_SUB_SSAT = 4'd4,
    OP_SUB_USAT = 4'd5,
    OP_CMP_EQ   = 4'd6,
    OP_CMP_GT   = 4'd7,
    OP_AND      = 4'd8,
    OP_ANDN     = 4'd9,
    OP_OR       = 4'd10,
    OP_XOR      = 4'd11
  } simd_op_e;

  typedef enum logic [1:0] {
    LS_8  = 2'd0,
    LS_16 = 2'd1,
    LS_32 = 2'd2,
    LS_64 = 2'd3
  } lane_sz_e;
endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import simd_pkg::*;

  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] sum;
  logic [W:0] dif;
  logic       add_sovf;
  logic       sub_sovf;
  logic       s_gt;

  always_comb begin
    sum = {1'b0, a} + {1'b0, b};
    dif = {1'b0, a} - {1'b0, b};
    // signed overflow: operand signs agree (add) or differ (sub) and result sign flips
    add_sovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    sub_sovf = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
    s_gt     = $signed(a) > $signed(b);
  end

  always_comb begin
    case (op)
      OP_ADD_WRAP: y = sum[W-1:0];
      OP_ADD_SSAT: y = add_sovf ? (a[W-1] ? SMIN : SMAX) : sum[W-1:0];
      OP_ADD_USAT: y = sum[W] ? ONES : sum[W-1:0];
      OP_SUB_WRAP: y = dif[W-1:0];
      OP_SUB_SSAT: y = sub_sovf ? (a[W-1] ? SMIN : SMAX) : dif[W-1:0];
      OP_SUB_USAT: y = dif[W] ? '0 : dif[W-1:0];
      OP_CMP_EQ:   y = (a == b) ? ONES : '0;
      OP_CMP_GT:   y = s_gt ? ONES : '0;
      OP_AND:      y = a & b;
      OP_ANDN:     y = ~a & b;
      OP_OR:       y = a | b;
      OP_XOR:      y = a ^ b;
      default:     y = '0;
    endcase
  end
endmodule

// File: rtl/simd_width_slice.sv
module simd_width_slice #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int N_LANES = DATA_W / LANE_W;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    simd_lane_unit #(.W(LANE_W)) u_lane (
      .op (op),
      .a  (a[g*LANE_W +: LANE_W]),
      .b  (b[g*LANE_W +: LANE_W]),
      .y  (y[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/simd_packed_alu.sv
module simd_packed_alu #(
  parameter int DATA_W = simd_pkg::SIMD_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [3:0]        op,
  input  logic [1:0]        lane_sz,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int N_SIZES = simd_pkg::SIMD_N_SIZES;

  logic [DATA_W-1:0] per_size [N_SIZES];
  logic [DATA_W-1:0] next_res;

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    simd_width_slice #(
      .DATA_W (DATA_W),
      .LANE_W (8 << s)
    ) u_slice (
      .op (op),
      .a  (src_a),
      .b  (src_b),
      .y  (per_size[s])
    );
  end

  assign next_res = per_size[lane_sz];
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_res;
    end
  end
endmodule

// File: rtl/simd_packed_alu_chk.sv
module simd_packed_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [3:0]        op,
  input logic [1:0]        lane_sz,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  logic take;
  assign take = in_valid && in_ready;

  function automatic logic lanes_uniform(logic [DATA_W-1:0] d, logic [1:0] sz);
    logic ok;
    int   lw;
    ok = 1'b1;
    lw = 8 << sz;
    for (int i = 0; i < DATA_W; i++) begin
      if (d[i] != d[i - (i % lw)]) ok = 1'b0;
    end
    return ok;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (!out_valid && out_data == '0); // R10
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  AST_MASK_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op == 4'd6 || op == 4'd7)) |=> lanes_uniform(out_data, $past(lane_sz))); // R5

  AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 4'd6 && src_a == src_b) |=> (out_data == {DATA_W{1'b1}})); // R5

  AST_WRAP_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 4'd0 && lane_sz == 2'd3) |=> (out_data == $past(src_a) + $past(src_b))); // R2

  AST_XOR_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 4'd11 && src_a == src_b) |=> (out_data == '0)); // R6

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op >= 4'd12) |=> (out_data == '0)); // R7
endmodule

bind simd_packed_alu simd_packed_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .src_a     (src_a),
  .src_b     (src_b),
  .op        (op),
  .lane_sz   (lane_sz),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/simd_packed_alu_bench.sv
module simd_packed_alu_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [3:0]  op = '0;
  logic [1:0]  lane_sz = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;

  int n_vec = 0;
  int n_bad = 0;

  logic [63:0] exp_q[$];
  int          op_q[$];

  always #(CLK_P/2) clk = ~clk;

  simd_packed_alu u_simd_packed_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .op(op), .lane_sz(lane_sz),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic string tag_of(int o);
    case (o)
      0, 3:          return "R2";
      1, 4:          return "R3";
      2, 5:          return "R4";
      6, 7:          return "R5";
      8, 9, 10, 11:  return "R6";
      default:       return "R7";
    endcase
  endfunction

  // behavioural lane model: wide signed/unsigned integers, clamped per lane
  function automatic logic [63:0] ref_op(logic [63:0] a, logic [63:0] b, int o, int sz);
    logic [63:0] r;
    int w;
    r = '0;
    w = 8 << sz;
    for (int i = 0; i < 64 / w; i++) begin
      logic [63:0] m, ua, ub, res;
      logic signed [65:0] sa, sb, t, smax, smin;
      logic [65:0] uu;
      m  = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
      ua = (a >> (i * w)) & m;
      ub = (b >> (i * w)) & m;
      sa = $signed({2'b00, ua});
      sb = $signed({2'b00, ub});
      if (ua[w-1]) sa = sa - (66'sd1 <<< w);
      if (ub[w-1]) sb = sb - (66'sd1 <<< w);
      smax = (66'sd1 <<< (w - 1)) - 66'sd1;
      smin = -(66'sd1 <<< (w - 1));
      case (o)
        0: res = ua + ub;
        1: begin t = sa + sb; res = (t > smax) ? smax[63:0] : (t < smin) ? smin[63:0] : t[63:0]; end
        2: begin uu = {2'b00, ua} + {2'b00, ub}; res = (uu > {2'b00, m}) ? m : uu[63:0]; end
        3: res = ua - ub;
        4: begin t = sa - sb; res = (t > smax) ? smax[63:0] : (t < smin) ? smin[63:0] : t[63:0]; end
        5: res = (ub > ua) ? 64'd0 : ua - ub;
        6: res = (ua == ub) ? m : 64'd0;
        7: res = (sa > sb) ? m : 64'd0;
        8: res = ua & ub;
        9: res = ~ua & ub;
        10: res = ua | ub;
        11: res = ua ^ ub;
        default: res = 64'd0;
      endcase
      r = r | ((res & m) << (i * w));
    end
    return r;
  endfunction

  task automatic chk(logic ok, string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // one beat with the output always drained; result checked one cycle later
  task automatic apply(logic [63:0] a, logic [63:0] b, int o, int sz, logic [63:0] exp, string req);
    @(negedge clk);
    src_a = a; src_b = b; op = 4'(o); lane_sz = 2'(sz);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R8", {63'd0, out_valid}, 64'd1);
    chk(out_data === exp, req, out_data, exp);
  endtask

  function automatic logic [63:0] pat(int k);
    case (k)
      0: return {8{8'h7F}};
      1: return {8{8'h80}};
      2: return {8{8'h01}};
      3: return 64'hFFFF_FFFF_FFFF_FFFF;
      4: return 64'd0;
      5: return {4{16'h7FFF}};
      6: return {2{32'h7FFF_FFFF}};
      7: return 64'h7FFF_FFFF_FFFF_FFFF;
      8: return 64'h8000_0000_0000_0000;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog R8 act=%h exp=%h", 64'd0, 64'd1);
    summary();
    $finish;
  end

  initial begin
    logic        stall_pend;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_data === 64'd0, "R10", out_data, 64'd0);
    rst_n = 1'b1;

    // directed boundary cases
    apply({8{8'h7F}}, {8{8'h01}}, 0, 0, {8{8'h80}}, "R2");
    apply({8{8'h7F}}, {8{8'h01}}, 1, 0, {8{8'h7F}}, "R3");
    apply({8{8'h80}}, {8{8'h01}}, 4, 0, {8{8'h80}}, "R3");
    apply({8{8'hFF}}, {8{8'h01}}, 2, 0, {8{8'hFF}}, "R4");
    apply(64'd0,      {8{8'h01}}, 5, 0, 64'd0,      "R4");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 64'hFFFF_FFFF_FFFF_FF00, "R1");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1, 64'hFFFF_FFFF_FFFF_0000, "R1");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 3, 64'd0, "R1");
    apply(64'h1122_3344_5566_7788, 64'h1122_0000_5566_0088, 6, 0, 64'hFFFF_0000_FFFF_00FF, "R5");
    apply(64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0000, 7, 2, 64'hFFFF_FFFF_0000_0000, "R5");
    apply(64'hFFFF_0000_FFFF_00FF, 64'hA1A2_A3A4_A5A6_A7A8, 8, 0, 64'hA1A2_0000_A5A6_00A8, "R6");
    apply(64'hFFFF_0000_FFFF_00FF, 64'hA1A2_A3A4_A5A6_A7A8, 9, 0, 64'h0000_A3A4_0000_A700, "R6");
    apply(64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, 13, 1, 64'd0, "R7");

    // every opcode at every lane size over boundary patterns
    for (int sz = 0; sz < 4; sz++) begin
      for (int o = 0; o < 16; o++) begin
        for (int k = 0; k < 9; k++) begin
          logic [63:0] a, b;
          case (k)
            0: begin a = pat(0); b = pat(2); end
            1: begin a = pat(1); b = pat(2); end
            2: begin a = pat(3); b = pat(2); end
            3: begin a = pat(4); b = pat(2); end
            4: begin a = pat(5); b = 64'h0001_0001_0001_0001; end
            5: begin a = pat(6); b = 64'h0000_0001_0000_0001; end
            6: begin a = pat(7); b = 64'd1; end
            7: begin a = pat(8); b = 64'd1; end
            default: begin a = pat(99); b = (o[0]) ? a : pat(99); end
          endcase
          apply(a, b, o, sz, ref_op(a, b, o, sz), tag_of(o));
        end
      end
    end

    // random streaming with back-pressure; queue-based ordering check
    stall_pend = 1'b0;
    held = '0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (c < 2900) begin
        in_valid  = ($urandom % 3) != 0;
        out_ready = ($urandom % 3) != 0;
        src_a = pat($urandom % 12);
        src_b = pat($urandom % 12);
        op = 4'($urandom % 16);
        lane_sz = 2'($urandom % 4);
      end else begin
        in_valid = 1'b0;
        out_ready = 1'b1;
      end
      #1;
      if (stall_pend) begin
        chk(out_valid === 1'b1 && out_data === held, "R9", out_data, held);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", out_data, 64'd0);
        end else begin
          logic [63:0] e;
          int          eo;
          e = exp_q.pop_front();
          eo = op_q.pop_front();
          chk(out_data === e, tag_of(eo), out_data, e);
        end
      end
      if (out_valid && !out_ready) begin
        chk(in_ready === 1'b0, "R9", {63'd0, in_ready}, 64'd0);
        stall_pend = 1'b1;
        held = out_data;
      end else begin
        stall_pend = 1'b0;
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_op(src_a, src_b, int'(op), int'(lane_sz)));
        op_q.push_back(int'(op));
      end
    end
    chk(exp_q.size() == 0, "R8", 64'(exp_q.size()), 64'd0);

    summary();
    $finish;
  end
endmodule